// File: doc/BRIEF.md
# Unsigned Integer to Single-Precision Float Converter

This block turns a 32-bit unsigned integer into the bit pattern of the IEEE-754 single-precision value nearest to it. Ties are rounded to even. Each operand arrives with a valid flag. The matching result leaves with its own valid flag exactly two clock cycles later. The block takes one new operand on every cycle and needs no gaps.

The first pipeline stage finds the position of the leading one and the unbiased exponent. It then shifts the operand, left or right, so that the leading one sits at the implicit-bit position. A right shift loses bits, so this stage reduces them to a round bit and a sticky bit. The second stage clears the implicit one and makes the rounding decision. It then forms the result with one addition of the significand, the increment and the shifted biased exponent. Any carry out of the significand therefore moves into the exponent field without extra logic.

Top module: `u2f_conv`

## Requirements
- R1: An operand of 0 produces the pattern 0x00000000 (+0.0).
- R2: Every operand below 2^24 is represented exactly. The exponent field (bits 30:23) holds 127 plus the bit index of the highest set bit. The fraction field (bits 22:0) holds the bits below the leading one, aligned to the left.
- R3: For a nonzero operand whose rounding does not carry, the exponent field equals 127 + 31 − (number of leading zero bits of the operand).
- R4: When the discarded low bits are worth more than half a unit in the last place, the magnitude is rounded up. Example: 0x02000003 gives 0x4C000001.
- R5: When the discarded bits are worth exactly half a unit in the last place, the result is the neighbour with an even fraction. Examples: 0x01000001 gives 0x4B800000, and 0x01000003 gives 0x4B800002.
- R6: When the discarded bits are worth less than half a unit in the last place, they are truncated. Example: 0x02000001 gives 0x4C000000.
- R7: A rounding carry out of the fraction raises the exponent by one and leaves a zero fraction. Examples: 0x01FFFFFF gives 0x4C000000, and 0xFFFFFFFF gives 0x4F800000.
- R8: Bit 31 of every valid result is 0. The exponent field of a valid result is never 0xFF.
- R9: out_valid is high exactly two cycles after in_valid was high. out_data then carries that operand's result. Operands on consecutive cycles each produce a result in the same order.
- R10: While rst is high at a clock edge, out_valid is low after that edge. This includes operands that were already inside the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Operand on in_data is valid this cycle |
| in_data | input | 32 | Unsigned integer operand |
| out_valid | output | 1 | Result on out_data is valid this cycle |
| out_data | output | 32 | Single-precision bit pattern of the result |

## Verification
The hardest cases to reach from the ports are those that depend on the exact pattern of the discarded bits. These are an exact half with an odd or an even kept significand, and a round-up that carries out of all 24 significand bits into the exponent. Random 32-bit operands almost never hit these cases. The stimulus therefore builds them on purpose, just above 2^24 and 2^25 and at the all-ones operand. Random operands are then streamed back to back against an independently written reference to cover the spread of exponents. A reset issued while operands are in flight checks that the valid pipeline is flushed.

// File: rtl/u2f_pkg.sv
package u2f_pkg;
  localparam int IN_W  = 32;
  localparam int MAN_W = 23;
  localparam int BIAS  = 127;
  localparam int LZ_W  = $clog2(IN_W) + 1;
  localparam int SIG_W = MAN_W + 1;

  typedef struct packed {
    logic             zero;
    logic [LZ_W-1:0]  expo;
    logic [SIG_W-1:0] sig;
    logic             rnd;
    logic             stk;
  } u2f_mid_t;

  // Count of zero bits above the highest set bit (IN_W for a zero word).
  function automatic logic [LZ_W-1:0] count_lead(input logic [IN_W-1:0] a);
    logic [LZ_W-1:0] n;
    logic            hit;
    n   = '0;
    hit = 1'b0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      if (!hit && a[i]) hit = 1'b1;
      if (!hit) n = n + 1'b1;
    end
    return n;
  endfunction

  // Round-to-nearest-even increment from kept lsb, round bit and sticky bit.
  function automatic logic rne_inc(input logic lsb, input logic rnd, input logic stk);
    return rnd & (stk | lsb);
  endfunction
endpackage

// File: rtl/u2f_lzc.sv
module u2f_lzc
  import u2f_pkg::*;
(
  input  logic [IN_W-1:0] a,
  output logic [LZ_W-1:0] cnt,
  output logic            is_zero
);
  always_comb begin
    cnt     = count_lead(a);
    is_zero = (a == '0);
  end
endmodule

// File: rtl/u2f_norm.sv
module u2f_norm
  import u2f_pkg::*;
(
  input  logic [IN_W-1:0] a,
  input  logic [LZ_W-1:0] lz,
  input  logic            is_zero,
  output u2f_mid_t        mid
);
  logic [LZ_W-1:0] expo;
  logic [LZ_W-1:0] sh;
  logic [IN_W-1:0] lsb_mask;
  logic [IN_W-1:0] low_mask;

  always_comb begin
    expo     = LZ_W'(IN_W - 1) - lz;
    sh       = expo - LZ_W'(MAN_W);
    lsb_mask = '0;
    low_mask = '0;
    mid.zero = is_zero;
    mid.expo = expo;
    mid.rnd  = 1'b0;
    mid.stk  = 1'b0;
    if (expo <= LZ_W'(MAN_W)) begin
      mid.sig = SIG_W'(a << (LZ_W'(MAN_W) - expo));
    end else begin
      mid.sig  = SIG_W'(a >> sh);
      lsb_mask = {{(IN_W-1){1'b0}}, 1'b1} << (sh - 1'b1);
      low_mask = ~({IN_W{1'b1}} << (sh - 1'b1));
      mid.rnd  = |(a & lsb_mask);
      mid.stk  = |(a & low_mask);
    end
  end
endmodule

// File: rtl/u2f_round.sv
module u2f_round
  import u2f_pkg::*;
(
  input  u2f_mid_t        mid,
  output logic            round_up,
  output logic [IN_W-1:0] data
);
  localparam logic [SIG_W-1:0] IMPL = SIG_W'(1) << MAN_W;
  logic [IN_W-1:0] frac;
  logic [IN_W-1:0] exp_part;

  always_comb begin
    round_up = rne_inc(mid.sig[0], mid.rnd, mid.stk);
    frac     = IN_W'(mid.sig ^ IMPL);
    exp_part = (IN_W'(mid.expo) + IN_W'(BIAS)) << MAN_W;
    data     = mid.zero ? '0 : (frac + IN_W'(round_up) + exp_part);
  end
endmodule

// File: rtl/u2f_conv.sv
module u2f_conv
  import u2f_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic [31:0] out_data
);
  logic [LZ_W-1:0] lz_cnt;
  logic            in_zero;
  u2f_mid_t        mid_d, mid_q;
  logic            v1;
  logic            round_up;
  logic [IN_W-1:0] res_d;

  u2f_lzc  u_lzc  (.a(in_data), .cnt(lz_cnt), .is_zero(in_zero));
  u2f_norm u_norm (.a(in_data), .lz(lz_cnt), .is_zero(in_zero), .mid(mid_d));

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
    if (in_valid) mid_q <= mid_d;
  end

  u2f_round u_round (.mid(mid_q), .round_up(round_up), .data(res_d));

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v1;
    if (v1) out_data <= res_d;
  end

  AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_data == '0) |=> ##1 (out_valid && out_data == '0)); // R1
  AST_LEAD_ONE_FOUND: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_zero) |-> in_data[IN_W - 1 - int'(lz_cnt)]); // R3
  AST_TIE_GIVES_EVEN: assert property (@(posedge clk) disable iff (rst)
    (v1 && !mid_q.zero && mid_q.rnd && !mid_q.stk) |=> !out_data[0]); // R5
  AST_SIGN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_data[31]); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_data[30:23] != 8'hFF)); // R8
  AST_TWO_CYCLE_VALID: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid); // R9
endmodule

// File: tb/tb_u2f_conv.sv
module tb_u2f_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  u2f_conv dut (.clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
                .out_valid(out_valid), .out_data(out_data));

  localparam int NV = 16;
  localparam logic [31:0] VIN [NV] = '{
    32'h00000000, 32'h00000001, 32'h00000002, 32'h00000003,
    32'h00000100, 32'h00FFFFFF, 32'h01000000, 32'h01000001,
    32'h01000003, 32'h01000002, 32'h02000001, 32'h02000003,
    32'h02000006, 32'h01FFFFFF, 32'hFFFFFFFF, 32'h80000000};
  localparam logic [31:0] VEXP [NV] = '{
    32'h00000000, 32'h3F800000, 32'h40000000, 32'h40400000,
    32'h43800000, 32'h4B7FFFFF, 32'h4B800000, 32'h4B800000,
    32'h4B800002, 32'h4B800001, 32'h4C000000, 32'h4C000001,
    32'h4C000002, 32'h4C000000, 32'h4F800000, 32'h4F000000};
  localparam string VTAG [NV] = '{
    "R1", "R2", "R2", "R2", "R2", "R2", "R3", "R5",
    "R5", "R3", "R6", "R4", "R5", "R7", "R7", "R3"};

  // Reference: integer quotient/remainder rounding, written independently.
  function automatic logic [31:0] ref_conv(input logic [31:0] a);
    int msb;
    longint unsigned q, r, half;
    int k;
    if (a == 0) return 32'h0;
    msb = 0;
    for (int i = 0; i < 32; i++) if (a[i]) msb = i;
    if (msb <= 23) begin
      q = longint'(a) << (23 - msb);
      k = msb;
    end else begin
      k    = msb;
      q    = longint'(a) >> (msb - 23);
      r    = longint'(a) - (q << (msb - 23));
      half = 64'd1 << (msb - 24);
      if (r > half || (r == half && q[0])) q = q + 1;
      if (q == (64'd1 << 24)) begin q = 64'd1 << 23; k = k + 1; end
    end
    return {1'b0, 8'(k + 127), q[22:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic convert_one(input logic [31:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); in_valid = 1'b1; in_data = a;
    @(negedge clk); in_valid = 1'b0;
    check("R9", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    check("R9", {31'b0, out_valid}, 32'd1);
    check(tag, out_data, exp);
    check("R8", {31'b0, out_data[31]}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] vals [200];
    repeat (3) @(negedge clk);
    check("R10", {31'b0, out_valid}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      convert_one(VIN[i], VEXP[i], VTAG[i]);
      check("R2", ref_conv(VIN[i]), VEXP[i]);
    end

    for (int i = 0; i < 24; i++) convert_one(32'd1 << i, ref_conv(32'd1 << i), "R2");
    for (int i = 24; i < 32; i++) convert_one(32'd1 << i, {1'b0, 8'(127 + i), 23'd0}, "R3");

    // Back-to-back stream of random operands
    for (int i = 0; i < 200; i++) vals[i] = $urandom() >> ($urandom() % 32);
    for (int i = 0; i < 202; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R9", {31'b0, out_valid}, 32'd1);
        check("R4", out_data, ref_conv(vals[i-2]));
      end
      if (i < 200) begin in_valid = 1'b1; in_data = vals[i]; end
      else in_valid = 1'b0;
    end
    @(negedge clk);
    check("R9", {31'b0, out_valid}, 32'd0);

    // Reset with operands in flight
    @(negedge clk); in_valid = 1'b1; in_data = 32'h12345678;
    @(negedge clk); in_data = 32'h00000005;
    @(negedge clk); rst = 1'b1; in_valid = 1'b0;
    @(negedge clk);
    check("R10", {31'b0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R10", {31'b0, out_valid}, 32'd0);
    @(negedge clk);
    check("R10", {31'b0, out_valid}, 32'd0);

    convert_one(32'h00FFFFFF, 32'h4B7FFFFF, "R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule